// File: doc/BRIEF.md
# Dual-Core Load Return Merge Buffer

This block gathers 128-bit load results coming back from the load/store units of two integer cores and hands them to one shared floating-point cluster. The cluster takes no more than two 128-bit loads per cycle. Each core may return up to two loads per cycle, so all four input slots can be busy at once. Whatever does not fit in the two output lanes is held in a small per-core store and sent out in later cycles.

Arbitration is round-robin between cores whenever both have work, so neither core can lock out the other. Loads from one core always leave in the order they arrived. When nothing is waiting, an arriving load goes straight to an output lane in the same cycle. Each core has a ready signal that tells it whether a full two-load burst can still be taken.

Top module: `lmb_merge_buffer`

## Requirements
- R1: During and right after reset, both output lanes are idle and both core ready signals are high.
- R2: At most two loads leave per cycle. Lane 1 carries a load only when lane 0 also carries one.
- R3: Loads from one core leave in arrival order, with data and 7-bit tag unchanged.
- R4: When a core has nothing stored and the lanes allow it, an accepted load appears on an output lane in the same cycle.
- R5: If both cores present two loads in one cycle with nothing stored, the older load of each core leaves in that cycle and the younger loads leave in the next cycle.
- R6: When both cores have loads available, lane 0 carries the oldest load of the core holding priority and lane 1 carries the oldest load of the other core. Priority then passes to the other core. Core 0 holds priority after reset.
- R7: When only one core has loads available, that core gets both lanes, or lane 0 alone if it has only one load.
- R8: Each core owns half of the DEPTH entries (4 with the default of 8). Its ready is high exactly when it stores no more than that half minus two loads.
- R9: Loads a core presents while its ready is low are discarded and never appear at the output.
- R10: Input slot 0 (data bits [127:0], tag bits [6:0], valid bit 0) is older than slot 1 (data bits [255:128], tag bits [13:7], valid bit 1). A valid pattern of 2'b10 presents one load, taken from slot 1. Output lane 0 uses the low halves and lane 1 the high halves, in the same way.
- R11: Whenever either core stores more than two loads, both output lanes carry a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core0_valid | input | 2 | Core 0 slot valid bits |
| core0_data | input | 256 | Core 0 load data, slot 0 in the low half |
| core0_tag | input | 14 | Core 0 destination tags, slot 0 in the low 7 bits |
| core0_ready | output | 1 | Core 0 may present a two-load burst |
| core1_valid | input | 2 | Core 1 slot valid bits |
| core1_data | input | 256 | Core 1 load data, slot 0 in the low half |
| core1_tag | input | 14 | Core 1 destination tags, slot 0 in the low 7 bits |
| core1_ready | output | 1 | Core 1 may present a two-load burst |
| out_valid | output | 2 | Output lane valid bits |
| out_data | output | 256 | Output load data, lane 0 in the low half |
| out_tag | output | 14 | Output destination tags, lane 0 in the low 7 bits |

## Verification
A corrupted read or write pointer in a per-core store shows up at once as wrong data or a wrong tag on lane 0 or lane 1, compared with the order that core supplied. A wrong occupancy count shows up as a ready edge that comes one cycle too early or too late. It can also show up as an idle lane while loads are still stored. A stuck or wrongly toggled priority bit puts the wrong core's load on lane 0 in the first cycle where both cores contend. A bad bypass path gives an idle lane in the same cycle that a load is accepted into an empty store.

// File: rtl/lmb_pkg.sv
package lmb_pkg;

    parameter int unsigned LMB_DATA_W = 128;
    parameter int unsigned LMB_TAG_W  = 7;
    parameter int unsigned LMB_NCORE  = 2;
    parameter int unsigned LMB_LANES  = 2;

    typedef struct packed {
        logic [LMB_TAG_W-1:0]  tag;
        logic [LMB_DATA_W-1:0] data;
    } load_t;

endpackage

// File: rtl/lmb_core_queue.sv
module lmb_core_queue
    import lmb_pkg::*;
#(
    parameter int unsigned PER = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  in_valid,
    input  load_t       in_item [2],
    output logic        ready,
    output load_t       cand [2],
    output logic [1:0]  avail,
    input  logic [1:0]  take
);

    localparam int unsigned PTR_W = (PER > 1) ? $clog2(PER) : 1;
    localparam int unsigned CNT_W = $clog2(PER + 1);

    typedef struct packed {
        load_t [PER-1:0]  ram;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t          st_d, st_q;
    logic [1:0]       acc;
    load_t            arr [2];
    logic [PTR_W-1:0] rd_nx;
    int               cnt_i, narr_i, take_i, pop_i, atk_i, total_i;

    assign ready = (st_q.cnt <= CNT_W'(PER - 2));

    always_comb begin
        st_d    = st_q;
        acc     = in_valid & {2{ready}};
        arr[0]  = acc[0] ? in_item[0] : in_item[1];
        arr[1]  = in_item[1];
        narr_i  = int'(acc[0]) + int'(acc[1]);
        cnt_i   = int'(st_q.cnt);
        rd_nx   = st_q.rd + PTR_W'(1);

        // stream view: stored loads first, then this cycle's arrivals
        cand[0] = (cnt_i >= 1) ? st_q.ram[st_q.rd] : arr[0];
        cand[1] = (cnt_i >= 2) ? st_q.ram[rd_nx]
                : ((cnt_i == 1) ? arr[0] : arr[1]);
        total_i = cnt_i + narr_i;
        avail   = (total_i >= 2) ? 2'd2 : 2'(total_i);

        take_i  = int'(take);
        pop_i   = (take_i > cnt_i) ? cnt_i : take_i;
        atk_i   = take_i - pop_i;

        for (int k = 0; k < 2; k++) begin
            if (atk_i + k < narr_i) begin
                st_d.ram[PTR_W'(int'(st_q.wr) + k)] = arr[atk_i + k];
            end
        end
        st_d.wr  = PTR_W'(int'(st_q.wr) + narr_i - atk_i);
        st_d.rd  = PTR_W'(int'(st_q.rd) + pop_i);
        st_d.cnt = CNT_W'(cnt_i - pop_i + narr_i - atk_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lmb_lane_arbiter.sv
module lmb_lane_arbiter
    import lmb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  avail [2],
    input  load_t       cand0 [2],
    input  load_t       cand1 [2],
    output logic [1:0]  lane_valid,
    output load_t       lane_item [2],
    output logic [1:0]  take [2]
);

    typedef struct packed {
        logic prio;
    } arb_t;

    arb_t  st_d, st_q;
    logic  p, q;
    load_t head_p [2];
    load_t head_q [2];

    always_comb begin
        st_d         = st_q;
        p            = st_q.prio;
        q            = ~st_q.prio;
        head_p       = p ? cand1 : cand0;
        head_q       = p ? cand0 : cand1;
        lane_valid   = 2'b00;
        lane_item[0] = '0;
        lane_item[1] = '0;
        take[0]      = 2'd0;
        take[1]      = 2'd0;

        if (avail[p] != 2'd0 && avail[q] != 2'd0) begin
            lane_valid   = 2'b11;
            lane_item[0] = head_p[0];
            lane_item[1] = head_q[0];
            take[p]      = 2'd1;
            take[q]      = 2'd1;
            st_d.prio    = q;
        end else if (avail[p] != 2'd0) begin
            lane_valid[0] = 1'b1;
            lane_item[0]  = head_p[0];
            take[p]       = 2'd1;
            if (avail[p] == 2'd2) begin
                lane_valid[1] = 1'b1;
                lane_item[1]  = head_p[1];
                take[p]       = 2'd2;
            end
        end else if (avail[q] != 2'd0) begin
            lane_valid[0] = 1'b1;
            lane_item[0]  = head_q[0];
            take[q]       = 2'd1;
            if (avail[q] == 2'd2) begin
                lane_valid[1] = 1'b1;
                lane_item[1]  = head_q[1];
                take[q]       = 2'd2;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lmb_merge_buffer.sv
module lmb_merge_buffer
    import lmb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        core0_valid,
    input  logic [LMB_LANES*LMB_DATA_W-1:0]   core0_data,
    input  logic [LMB_LANES*LMB_TAG_W-1:0]    core0_tag,
    output logic                              core0_ready,
    input  logic [1:0]                        core1_valid,
    input  logic [LMB_LANES*LMB_DATA_W-1:0]   core1_data,
    input  logic [LMB_LANES*LMB_TAG_W-1:0]    core1_tag,
    output logic                              core1_ready,
    output logic [1:0]                        out_valid,
    output logic [LMB_LANES*LMB_DATA_W-1:0]   out_data,
    output logic [LMB_LANES*LMB_TAG_W-1:0]    out_tag
);

    localparam int unsigned PER = DEPTH / LMB_NCORE;

    logic [1:0]                      v_in   [LMB_NCORE];
    logic [LMB_LANES*LMB_DATA_W-1:0] d_in   [LMB_NCORE];
    logic [LMB_LANES*LMB_TAG_W-1:0]  t_in   [LMB_NCORE];
    logic                            rdy    [LMB_NCORE];
    logic [1:0]                      avail  [LMB_NCORE];
    logic [1:0]                      take   [LMB_NCORE];
    load_t                           c0_in  [2];
    load_t                           c1_in  [2];
    load_t                           c0_cand[2];
    load_t                           c1_cand[2];
    load_t                           lane   [2];

    assign v_in[0] = core0_valid;
    assign v_in[1] = core1_valid;
    assign d_in[0] = core0_data;
    assign d_in[1] = core1_data;
    assign t_in[0] = core0_tag;
    assign t_in[1] = core1_tag;
    assign core0_ready = rdy[0];
    assign core1_ready = rdy[1];

    for (genvar s = 0; s < LMB_LANES; s++) begin : g_slot
        assign c0_in[s].data = d_in[0][s*LMB_DATA_W +: LMB_DATA_W];
        assign c0_in[s].tag  = t_in[0][s*LMB_TAG_W  +: LMB_TAG_W];
        assign c1_in[s].data = d_in[1][s*LMB_DATA_W +: LMB_DATA_W];
        assign c1_in[s].tag  = t_in[1][s*LMB_TAG_W  +: LMB_TAG_W];
        assign out_data[s*LMB_DATA_W +: LMB_DATA_W] = lane[s].data;
        assign out_tag[s*LMB_TAG_W  +: LMB_TAG_W]   = lane[s].tag;
    end

    lmb_core_queue #(.PER(PER)) u_q0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(v_in[0]),
        .in_item (c0_in),
        .ready   (rdy[0]),
        .cand    (c0_cand),
        .avail   (avail[0]),
        .take    (take[0])
    );

    lmb_core_queue #(.PER(PER)) u_q1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(v_in[1]),
        .in_item (c1_in),
        .ready   (rdy[1]),
        .cand    (c1_cand),
        .avail   (avail[1]),
        .take    (take[1])
    );

    lmb_lane_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .avail     (avail),
        .cand0     (c0_cand),
        .cand1     (c1_cand),
        .lane_valid(out_valid),
        .lane_item (lane),
        .take      (take)
    );

endmodule

// File: rtl/lmb_merge_chk.sv
module lmb_merge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] core0_valid,
    input logic       core0_ready,
    input logic [1:0] core1_valid,
    input logic       core1_ready,
    input logic [1:0] out_valid
);

    // R2
    lane_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[1] |-> out_valid[0]);

    // R4
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|core0_valid && core0_ready) || (|core1_valid && core1_ready)) |-> out_valid[0]);

    // R8
    ready0_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core0_ready) |-> $past(|core0_valid && core0_ready));

    // R8
    ready1_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core1_ready) |-> $past(|core1_valid && core1_ready));

    // R8
    ready0_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core0_ready) |-> $past(out_valid[0]));

    // R8
    ready1_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core1_ready) |-> $past(out_valid[0]));

    // R11
    full_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core0_ready || !core1_ready) |-> (out_valid == 2'b11));

endmodule

bind lmb_merge_buffer lmb_merge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core0_valid(core0_valid),
    .core0_ready(core0_ready),
    .core1_valid(core1_valid),
    .core1_ready(core1_ready),
    .out_valid  (out_valid)
);

// File: tb/lmb_merge_buffer_tb.sv
`timescale 1ns/1ps
module lmb_merge_buffer_tb;

    localparam int PER = 4;
    typedef logic [134:0] it_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   vin [2];
    logic [255:0] din [2];
    logic [13:0]  tin [2];
    logic         core0_ready, core1_ready;
    logic [1:0]   out_valid;
    logic [255:0] out_data;
    logic [13:0]  out_tag;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    it_t mq [2][$];
    int  prio   = 0;

    always #4 clk = ~clk;

    lmb_merge_buffer #(.DEPTH(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .core0_valid(vin[0]),
        .core0_data (din[0]),
        .core0_tag  (tin[0]),
        .core0_ready(core0_ready),
        .core1_valid(vin[1]),
        .core1_data (din[1]),
        .core1_tag  (tin[1]),
        .core1_ready(core1_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_tag    (out_tag)
    );

    task automatic check_eq(input string lbl, input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    // compute expected outputs from the model, compare, then advance the model
    task automatic model_cycle(input string lbl);
        it_t       s [2][$];
        int        a [2];
        int        tk [2];
        logic [1:0] er, ev;
        it_t       el [2];
        int        p, q;
        for (int c = 0; c < 2; c++) begin
            s[c]  = mq[c];
            er[c] = (mq[c].size() <= PER - 2);
            if (er[c]) begin
                if (vin[c][0]) s[c].push_back({tin[c][6:0],  din[c][127:0]});
                if (vin[c][1]) s[c].push_back({tin[c][13:7], din[c][255:128]});
            end
            a[c]  = (s[c].size() > 2) ? 2 : s[c].size();
            tk[c] = 0;
        end
        p = prio; q = 1 - prio;
        ev = 2'b00; el[0] = '0; el[1] = '0;
        if (a[p] > 0 && a[q] > 0) begin
            ev = 2'b11; el[0] = s[p][0]; el[1] = s[q][0];
            tk[p] = 1; tk[q] = 1; prio = q;
        end else if (a[p] > 0) begin
            ev = 2'b01; el[0] = s[p][0]; tk[p] = 1;
            if (a[p] == 2) begin ev = 2'b11; el[1] = s[p][1]; tk[p] = 2; end
        end else if (a[q] > 0) begin
            ev = 2'b01; el[0] = s[q][0]; tk[q] = 1;
            if (a[q] == 2) begin ev = 2'b11; el[1] = s[q][1]; tk[q] = 2; end
        end
        check_eq("R8 ready", {134'd0, core1_ready, core0_ready}, {134'd0, er});
        check_eq({lbl, " valid"}, {134'd0, out_valid}, {134'd0, ev});
        if (ev[0]) check_eq({lbl, " lane0"}, {1'b0, out_tag[6:0],  out_data[127:0]},   {1'b0, el[0]});
        if (ev[1]) check_eq({lbl, " lane1"}, {1'b0, out_tag[13:7], out_data[255:128]}, {1'b0, el[1]});
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < tk[c]; k++) void'(s[c].pop_front());
            mq[c] = s[c];
        end
    endtask

    task automatic step(input logic [1:0] v0, input logic [1:0] v1, input string lbl);
        @(negedge clk);
        vin[0] = v0;
        vin[1] = v1;
        for (int c = 0; c < 2; c++) begin
            din[c] = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            tin[c] = 14'($urandom);
        end
        #1;
        model_cycle(lbl);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        void'($urandom(32'h5A17));
        vin[0] = 2'b00; vin[1] = 2'b00;
        din[0] = '0; din[1] = '0; tin[0] = '0; tin[1] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        check_eq("R1 reset valid", {134'd0, out_valid}, 136'd0);
        check_eq("R1 reset ready", {134'd0, core1_ready, core0_ready}, {134'd0, 2'b11});
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_eq("R1 after reset", {132'd0, core1_ready, core0_ready, out_valid}, {132'd0, 4'b1100});

        // R4 R7: one core, two loads, straight through
        step(2'b11, 2'b00, "R4 R7 bypass");
        step(2'b00, 2'b00, "R4 idle");
        // R10: single load from slot 1
        step(2'b00, 2'b10, "R10 slot1 only");
        step(2'b01, 2'b00, "R10 slot0 only");
        // R5 R6: four loads in one cycle, drained over two
        step(2'b11, 2'b11, "R5 R6 burst");
        step(2'b00, 2'b00, "R5 R6 drain");
        step(2'b00, 2'b00, "R5 empty");
        // R8 R9: sustained overload from both cores
        for (int i = 0; i < 6; i++) step(2'b11, 2'b11, "R8 R9 R11 overload");
        for (int i = 0; i < 6; i++) step(2'b00, 2'b00, "R3 R11 drain");
        // one core overloaded, other silent
        for (int i = 0; i < 4; i++) step(2'b11, 2'b00, "R7 R9 single");
        for (int i = 0; i < 4; i++) step(2'b00, 2'b00, "R7 drain");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] r0, r1;
            r0 = 2'($urandom);
            r1 = 2'($urandom);
            if (($urandom % 8) < 3) r0 = 2'b00;
            if (($urandom % 8) < 3) r1 = 2'b00;
            step(r0, r1, "R2 R3 R6 R7 R9 R11 random");
        end
        for (int i = 0; i < 6; i++) step(2'b00, 2'b00, "R3 final drain");
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

endmodule